// File: doc/BRIEF.md
# Polarity-Selectable GPIO Edge Latch

This block watches a bank of twenty slow digital input lines and records, in a sticky status register, the lines that have made a chosen transition. The lines are sixteen data inputs, two strobe inputs, one external interrupt request input and one spare input. Each line has its own polarity bit. The bit turns the raw level into a logical level, and a logical low-to-high step is the event that is recorded. A polarity of 0 therefore captures rising pins and a polarity of 1 captures falling pins.

Software reaches four registers through a simple synchronous port: polarity, latch enable, latch status and interrupt enable. Software reads the status and writes a mask back to the status address to clear only the bits it has handled. A single interrupt output stays high while any latched line also has its interrupt enable set. Every input passes through a synchronizer before edge detection, so the pins may be asynchronous to the clock.

Top module: `gpio_edge_latch`

## Requirements
- R1: After reset the polarity, latch-enable, status and interrupt-enable registers read zero and `irq` is low.
- R2: Register addresses are 0 polarity, 1 latch enable, 2 status, 3 interrupt enable. Bit positions are data lines 0..15, strobe lines 16..17, external request line 18 and spare line 19. Polarity, latch enable and interrupt enable read back the last value written. A write to address 2 never sets a status bit.
- R3: With polarity 0, a low-to-high pin transition on an enabled line sets its status bit. A high-to-low transition does not.
- R4: With polarity 1, a high-to-low pin transition on an enabled line sets its status bit. A low-to-high transition does not.
- R5: A transition on a line whose latch-enable bit is 0 leaves its status bit unchanged.
- R6: A write to address 2 clears exactly the status bits that are 1 in the written mask. All other status bits keep their value.
- R7: When a new capture and a clear of the same bit fall in the same clock, the bit ends up set.
- R8: `irq` is high exactly when some status bit is set and its interrupt-enable bit is also set. It stays high until those bits are cleared or disabled.
- R9: Writing a new polarity while the pin is steady never sets a status bit.
- R10: A pin transition appears in the status register on the third rising clock edge after the pin changes: two synchronizer stages, then the status flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 16 | Data input lines, status bits 0..15 |
| strobe_in | input | 2 | Strobe input lines, status bits 16..17 |
| ext_req_in | input | 1 | External request line, status bit 18 |
| spare_in | input | 1 | Spare line, status bit 19 |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 20 | Write data, or the clear mask at address 2 |
| rd_data | output | 20 | Combinational read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things. A status bit rises only on a line that was enabled. A status bit falls only when a clear mask covered it. A polarity write over steady pins produces no edge, and `irq` stays low while no interrupt is enabled. Edge direction per polarity, the exact three-clock latency, a capture that collides with a clear, and the masking effect of the interrupt enable can only be shown by the directed scenarios. In those scenarios the pins are driven and the bench reads the results back through the register port.

// File: rtl/gel_pkg.sv
package gel_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_POL  = 2'd0,
      REG_LEN  = 2'd1,
      REG_STAT = 2'd2,
      REG_IEN  = 2'd3
   } gel_reg_e;
endpackage

// File: rtl/gel_sync.sv
module gel_sync #(
   parameter int WIDTH  = 20,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[LAST];
endmodule

// File: rtl/gel_edge.sv
module gel_edge #(
   parameter int WIDTH = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic [WIDTH-1:0] pol_q_i,
   input  logic [WIDTH-1:0] pol_d_i,
   output logic [WIDTH-1:0] edge_o
);
   // History is stored in the logical domain and is built with the polarity
   // that will be in force next cycle, so a polarity write reloads it.
   logic [WIDTH-1:0] hist_q;
   logic [WIDTH-1:0] logical_now;

   assign logical_now = sync_i ^ pol_q_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= sync_i ^ pol_d_i;
   end

   assign edge_o = logical_now & ~hist_q;
endmodule

// File: rtl/gel_regs.sv
module gel_regs
   import gel_pkg::*;
#(
   parameter int WIDTH = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [WIDTH-1:0]  edge_i,
   output logic [WIDTH-1:0]  pol_q,
   output logic [WIDTH-1:0]  pol_d,
   output logic [WIDTH-1:0]  len_q,
   output logic [WIDTH-1:0]  stat_q,
   output logic [WIDTH-1:0]  ien_q,
   output logic [WIDTH-1:0]  rd_data
);
   gel_reg_e         sel;
   logic [WIDTH-1:0] clr_mask;
   logic [WIDTH-1:0] stat_d;

   assign sel = gel_reg_e'(addr);

   always_comb begin
      pol_d = pol_q;
      if (wr_en && sel == REG_POL) pol_d = wr_data;
   end

   assign clr_mask = (wr_en && sel == REG_STAT) ? wr_data : '0;
   // A fresh capture overrides a clear of the same bit.
   assign stat_d   = (stat_q & ~clr_mask) | (edge_i & len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         len_q  <= '0;
         stat_q <= '0;
         ien_q  <= '0;
      end else begin
         pol_q  <= pol_d;
         stat_q <= stat_d;
         if (wr_en && sel == REG_LEN) len_q <= wr_data;
         if (wr_en && sel == REG_IEN) ien_q <= wr_data;
      end
   end

   always_comb begin
      unique case (sel)
         REG_POL:  rd_data = pol_q;
         REG_LEN:  rd_data = len_q;
         REG_STAT: rd_data = stat_q;
         REG_IEN:  rd_data = ien_q;
      endcase
   end
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch
   import gel_pkg::*;
#(
   parameter int DATA_LINES   = 16,
   parameter int STROBE_LINES = 2,
   parameter int SYNC_STAGES  = 2,
   localparam int NUM_LINES   = DATA_LINES + STROBE_LINES + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DATA_LINES-1:0]   data_in,
   input  logic [STROBE_LINES-1:0] strobe_in,
   input  logic                    ext_req_in,
   input  logic                    spare_in,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr_en,
   input  logic [NUM_LINES-1:0]    wr_data,
   output logic [NUM_LINES-1:0]    rd_data,
   output logic                    irq
);
   generate
      if (DATA_LINES < 1 || STROBE_LINES < 1) begin : g_bad_groups
         $error("gpio_edge_latch: every line group needs at least one line");
      end
      if (NUM_LINES > 32) begin : g_bad_width
         $error("gpio_edge_latch: at most 32 lines fit the register port");
      end
   endgenerate

   logic [NUM_LINES-1:0] raw_lines;
   logic [NUM_LINES-1:0] sync_lines;
   logic [NUM_LINES-1:0] edge_vec;
   logic [NUM_LINES-1:0] pol_q, pol_d, len_q, stat_q, ien_q;

   assign raw_lines = {spare_in, ext_req_in, strobe_in, data_in};

   gel_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines),
      .sync_o (sync_lines)
   );

   gel_edge #(.WIDTH(NUM_LINES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (sync_lines),
      .pol_q_i (pol_q),
      .pol_d_i (pol_d),
      .edge_o  (edge_vec)
   );

   gel_regs #(.WIDTH(NUM_LINES)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .edge_i  (edge_vec),
      .pol_q   (pol_q),
      .pol_d   (pol_d),
      .len_q   (len_q),
      .stat_q  (stat_q),
      .ien_q   (ien_q),
      .rd_data (rd_data)
   );

   assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/gel_chk.sv
module gel_chk
   import gel_pkg::*;
#(
   parameter int NUM_LINES = 20
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    addr,
   input logic                 wr_en,
   input logic [NUM_LINES-1:0] wr_data,
   input logic                 irq,
   input logic [NUM_LINES-1:0] pol_q,
   input logic [NUM_LINES-1:0] len_q,
   input logic [NUM_LINES-1:0] stat_q,
   input logic [NUM_LINES-1:0] ien_q,
   input logic [NUM_LINES-1:0] sync_lines,
   input logic [NUM_LINES-1:0] edge_vec
);
   logic [NUM_LINES-1:0] clr_seen_q;
   logic                 pol_wr_q;
   logic                 ien_wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_seen_q <= '0;
         pol_wr_q   <= 1'b0;
         ien_wr_q   <= 1'b0;
      end else begin
         clr_seen_q <= (wr_en && addr == REG_STAT) ? wr_data : '0;
         pol_wr_q   <= wr_en && addr == REG_POL;
         ien_wr_q   <= wr_en && addr == REG_IEN;
      end
   end

   // R5
   set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~$past(stat_q) & ~$past(len_q)) == '0);

   // R6
   drop_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~stat_q & $past(stat_q) & ~clr_seen_q) == '0);

   // R9
   pol_write_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_wr_q && $stable(sync_lines)) |-> (edge_vec == '0));

   // R2
   pol_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_POL) |=> (pol_q == $past(wr_data)));

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && clr_seen_q == '0 && !ien_wr_q) |-> irq);
endmodule

bind gpio_edge_latch gel_chk #(.NUM_LINES(NUM_LINES)) u_gel_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .irq        (irq),
   .pol_q      (pol_q),
   .len_q      (len_q),
   .stat_q     (stat_q),
   .ien_q      (ien_q),
   .sync_lines (sync_lines),
   .edge_vec   (edge_vec)
);

// File: tb/gpio_edge_latch_test.sv
module gpio_edge_latch_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 20;
   localparam logic [1:0] A_POL = 2'd0, A_LEN = 2'd1, A_STAT = 2'd2, A_IEN = 2'd3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] lines = '0;
   logic [1:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic [N-1:0] wr_data = '0;
   logic [N-1:0] rd_data;
   logic         irq;
   int           n_checks = 0;
   int           n_fail = 0;
   bit           done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_latch uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_in    (lines[15:0]),
      .strobe_in  (lines[17:16]),
      .ext_req_in (lines[18]),
      .spare_in   (lines[19]),
      .addr       (addr),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .irq        (irq)
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %05h expected %05h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic expect_reg(input string req, input logic [1:0] a, input logic [N-1:0] exp);
      logic [N-1:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset;
      expect_reg("R1 pol", A_POL, '0);
      expect_reg("R1 len", A_LEN, '0);
      expect_reg("R1 stat", A_STAT, '0);
      expect_reg("R1 ien", A_IEN, '0);
      check("R1 irq", N'(irq), '0);
   endtask

   task automatic t_readback;
      @(negedge clk);
      wr(A_POL, 20'h5A5A5);
      wr(A_LEN, 20'hF0F0F);
      wr(A_IEN, 20'h12345);
      wr(A_STAT, 20'hFFFFF);
      expect_reg("R2 pol", A_POL, 20'h5A5A5);
      expect_reg("R2 len", A_LEN, 20'hF0F0F);
      expect_reg("R2 ien", A_IEN, 20'h12345);
      expect_reg("R2 stat write never sets", A_STAT, '0);
      @(negedge clk);
      wr(A_POL, '0);
      wr(A_LEN, '0);
      wr(A_IEN, '0);
      wait_neg(2);
   endtask

   task automatic t_rise;
      wr(A_LEN, 20'h00008);
      lines[3] = 1'b1;
      wait_neg(2);
      expect_reg("R10 not yet after two edges", A_STAT, '0);
      wait_neg(1);
      expect_reg("R3 rise latched, R10 third edge", A_STAT, 20'h00008);
      @(negedge clk);
      wr(A_STAT, 20'h00008);
      expect_reg("R6 single clear", A_STAT, '0);
      lines[3] = 1'b0;
      wait_neg(4);
      expect_reg("R3 fall ignored", A_STAT, '0);
   endtask

   task automatic t_fall;
      @(negedge clk);
      wr(A_POL, 20'h10000);
      wr(A_LEN, 20'h10000);
      lines[16] = 1'b1;
      wait_neg(4);
      expect_reg("R4 rise ignored", A_STAT, '0);
      @(negedge clk);
      lines[16] = 1'b0;
      wait_neg(3);
      expect_reg("R4 fall latched", A_STAT, 20'h10000);
      @(negedge clk);
      wr(A_STAT, 20'h10000);
      wr(A_POL, '0);
      wait_neg(3);
   endtask

   task automatic t_disabled;
      wr(A_LEN, 20'h00100);
      lines[7] = 1'b1;
      lines[8] = 1'b1;
      wait_neg(4);
      expect_reg("R5 only enabled line latched", A_STAT, 20'h00100);
      @(negedge clk);
      wr(A_STAT, 20'hFFFFF);
      lines[7] = 1'b0;
      lines[8] = 1'b0;
      wait_neg(4);
   endtask

   task automatic t_mask;
      wr(A_LEN, 20'h00007);
      lines[2:0] = 3'b111;
      wait_neg(4);
      expect_reg("R6 three latched", A_STAT, 20'h00007);
      @(negedge clk);
      wr(A_STAT, 20'h00005);
      expect_reg("R6 mask clears only its bits", A_STAT, 20'h00002);
      @(negedge clk);
      wr(A_STAT, 20'h00002);
      lines[2:0] = 3'b000;
      wait_neg(4);
   endtask

   task automatic t_collide;
      wr(A_LEN, 20'h00003);
      lines[1:0] = 2'b11;
      wait_neg(4);
      lines[0] = 1'b0;
      wait_neg(4);
      expect_reg("R7 both latched before", A_STAT, 20'h00003);
      @(negedge clk);
      lines[0] = 1'b1;
      wait_neg(2);
      wr(A_STAT, 20'h00003);
      expect_reg("R7 capture beats clear", A_STAT, 20'h00001);
      @(negedge clk);
      wr(A_STAT, 20'hFFFFF);
      lines[1:0] = 2'b00;
      wait_neg(4);
   endtask

   task automatic t_irq;
      wr(A_LEN, 20'h60000);
      wr(A_IEN, 20'h40000);
      lines[17] = 1'b1;
      wait_neg(4);
      check("R8 masked line no irq", N'(irq), '0);
      lines[18] = 1'b1;
      wait_neg(4);
      check("R8 enabled line irq", N'(irq), 20'h1);
      wait_neg(5);
      check("R8 irq held", N'(irq), 20'h1);
      wr(A_STAT, 20'h20000);
      check("R8 clear other bit keeps irq", N'(irq), 20'h1);
      wr(A_STAT, 20'h40000);
      check("R8 clear drops irq", N'(irq), '0);
      lines[18:17] = 2'b00;
      wr(A_IEN, '0);
      wait_neg(4);
   endtask

   task automatic t_polchange;
      wr(A_STAT, 20'hFFFFF);
      wr(A_LEN, 20'h00020);
      wr(A_POL, 20'h00020);
      wait_neg(4);
      expect_reg("R9 pol 0->1 on low pin", A_STAT, '0);
      lines[5] = 1'b1;
      wait_neg(4);
      wr(A_POL, '0);
      wait_neg(4);
      expect_reg("R9 pol 1->0 on high pin", A_STAT, '0);
      lines[5] = 1'b0;
      wait_neg(4);
      expect_reg("R9 later fall still ignored", A_STAT, '0);
   endtask

   initial begin
      wait_neg(3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_readback();
      t_rise();
      t_fall();
      t_disabled();
      t_mask();
      t_collide();
      t_irq();
      t_polchange();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule